// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block holds two small pending vectors for a cluster of up to four CPUs. One vector is for inter-processor interrupts (IPIs) and one is for interval-timer interrupts. Each pending bit drives a level output to its CPU: the IPI level output and the timer level output. Software changes the IPI vector through a single 64-bit control word. That word has three independent 4-bit fields: IPI request, IPI clear and timer clear. A periodic tick from an external timer posts a timer interrupt to every CPU.

The block does not act on a request for an IPI that is already pending, and it does not act on a clear for an IPI that is not pending. It reports each of these for one cycle on a per-CPU flag vector. A status read returns both vectors together with the ID of the CPU that is reading. The parameter `NCPU` (1 to 4) sets how many CPUs take part. Field bits for CPUs that do not exist are ignored.

Top module: `ipi_timer_intc`

## Requirements
- R1: Bits [15:12] of a write (bit 12 for CPU 0) request IPIs. Each requested CPU without a pending IPI gets its IPI pending bit set, and its `ipi_irq` output rises.
- R2: A request aimed at a CPU whose IPI is still pending leaves that CPU's state unchanged. It sets that CPU's bit in `ipi_dup` for exactly one cycle.
- R3: Bits [11:8] (bit 8 for CPU 0) clear pending IPIs, and `ipi_irq` drops. A clear aimed at a CPU with no pending IPI sets that CPU's bit in `ipi_miss` for one cycle.
- R4: Bits [7:4] (bit 4 for CPU 0) clear the timer interrupts of the CPUs that have one pending, and `tmr_irq` drops. The IPI state is not affected.
- R5: A cycle with `tick` high sets the timer pending bit of every existing CPU. When a tick and a timer clear fall in the same cycle, the tick wins.
- R6: `rd_data` holds the IPI vector in bits [11:8], the timer vector in bits [7:4] and `rd_cpu_id` in bits [1:0]. All other bits are zero.
- R7: Field bits for CPUs numbered `NCPU` or above have no effect. Their read positions stay zero.
- R8: When one write both clears and requests the IPI of the same CPU, the clear is applied first. The IPI ends pending, and neither the duplicate flag nor the miss flag is raised for that request.
- R9: Write bits outside [15:4] are ignored. State and flags change only on the clock edge after a cycle with `wr_en` high. With `wr_en` low, the flags are zero.
- R10: A synchronous active-high `rst` clears both vectors and both flag vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 64 | Control word |
| tick | input | 1 | Timer tick, posts timer interrupts |
| rd_cpu_id | input | 2 | ID of the CPU issuing the read |
| rd_data | output | 64 | Status word |
| ipi_irq | output | NCPU | Level IPI output per CPU |
| tmr_irq | output | NCPU | Level timer output per CPU |
| ipi_dup | output | NCPU | One-cycle flag: request hit a pending IPI |
| ipi_miss | output | NCPU | One-cycle flag: clear hit a non-pending IPI |

## Verification
The bench builds the block with `NCPU` = 3. Bits 15, 11 and 7 of the word therefore address a CPU that does not exist. Setting them shows whether the block ignores them and keeps bits 11 and 7 of the read word at zero, which cannot be observed at the default of four CPUs. The directed writes, followed by a long stream of random words, ticks and read IDs, reach these cases:
- clear and request of the same CPU in one word
- tick together with a timer clear
- writes that carry junk in the unused bits

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int FLD_W    = 4;
    localparam int WORD_W   = 64;
    localparam int REQ_LSB  = 12;
    localparam int CLR_LSB  = 8;
    localparam int TCLR_LSB = 4;
    localparam int ID_W     = 2;

    typedef struct packed {
        logic [FLD_W-1:0] ipi_req;
        logic [FLD_W-1:0] ipi_clr;
        logic [FLD_W-1:0] tmr_clr;
    } ctl_fields_t;

    function automatic ctl_fields_t split_word(input logic [WORD_W-1:0] w);
        ctl_fields_t f;
        f.ipi_req = w[REQ_LSB  +: FLD_W];
        f.ipi_clr = w[CLR_LSB  +: FLD_W];
        f.tmr_clr = w[TCLR_LSB +: FLD_W];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic [FLD_W-1:0] ipi,
                                                      input logic [FLD_W-1:0] tmr,
                                                      input logic [ID_W-1:0]  id);
        logic [WORD_W-1:0] s;
        s = '0;
        s[CLR_LSB  +: FLD_W] = ipi;
        s[TCLR_LSB +: FLD_W] = tmr;
        s[ID_W-1:0]          = id;
        return s;
    endfunction
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import intc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NCPU-1:0]   req,
    output logic [NCPU-1:0]   clr,
    output logic [NCPU-1:0]   tclr
);
    ctl_fields_t f;

    always_comb begin
        f    = split_word(wr_data);
        req  = wr_en ? f.ipi_req[NCPU-1:0] : '0;
        clr  = wr_en ? f.ipi_clr[NCPU-1:0] : '0;
        tclr = wr_en ? f.tmr_clr[NCPU-1:0] : '0;
    end
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCPU-1:0] req,
    input  logic [NCPU-1:0] clr,
    output logic [NCPU-1:0] pend,
    output logic [NCPU-1:0] dup,
    output logic [NCPU-1:0] miss
);
    logic [NCPU-1:0] after_clr, pend_n, dup_n, miss_n;

    always_comb begin
        after_clr = pend & ~clr;
        pend_n    = after_clr | req;
        dup_n     = req & after_clr;
        miss_n    = clr & ~pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            dup  <= '0;
            miss <= '0;
        end else begin
            pend <= pend_n;
            dup  <= dup_n;
            miss <= miss_n;
        end
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        // R1
        ipi_post_chk: assert property (@(posedge clk) disable iff (rst)
            (req[i] && !pend[i]) |=> pend[i]);
        // R3
        ipi_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !req[i]) |=> !pend[i]);
        // R2
        ipi_dup_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (req[i] && pend[i] && !clr[i]) |=> (pend[i] && dup[i]));
    end
    // R9
    ipi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0 && clr == '0) |=> (dup == '0 && miss == '0 && $stable(pend)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [NCPU-1:0] tclr,
    output logic [NCPU-1:0] pend
);
    logic [NCPU-1:0] pend_n;

    always_comb begin
        pend_n = pend & ~tclr;
        if (tick) pend_n = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_n;
    end

    // R5
    tmr_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pend == {NCPU{1'b1}}));
    // R4
    tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && tclr != '0) |=> ((pend & $past(tclr)) == '0));
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
    import intc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              tick,
    input  logic [1:0]        rd_cpu_id,
    output logic [63:0]       rd_data,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   tmr_irq,
    output logic [NCPU-1:0]   ipi_dup,
    output logic [NCPU-1:0]   ipi_miss
);
    logic [NCPU-1:0]  req, clr, tclr;
    logic [FLD_W-1:0] ipi_w, tmr_w;

    ctl_decode #(.NCPU(NCPU)) u_dec (
        .wr_en(wr_en), .wr_data(wr_data), .req(req), .clr(clr), .tclr(tclr));

    ipi_bank #(.NCPU(NCPU)) u_ipi (
        .clk(clk), .rst(rst), .req(req), .clr(clr),
        .pend(ipi_irq), .dup(ipi_dup), .miss(ipi_miss));

    tmr_bank #(.NCPU(NCPU)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick), .tclr(tclr), .pend(tmr_irq));

    always_comb begin
        ipi_w = '0;
        tmr_w = '0;
        ipi_w[NCPU-1:0] = ipi_irq;
        tmr_w[NCPU-1:0] = tmr_irq;
        rd_data = pack_status(ipi_w, tmr_w, rd_cpu_id);
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ipi_irq == '0 && tmr_irq == '0 && ipi_dup == '0 && ipi_miss == '0));
    // R2
    dup_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (ipi_dup & ~ipi_irq) == '0);
endmodule

// File: tb/test_ipi_timer_intc.sv
module test_ipi_timer_intc;
    localparam int PERIOD = 10;
    localparam int N = 3;

    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [63:0] wr_data = '0;
    logic        tick = 0;
    logic [1:0]  rd_cpu_id = '0;
    logic [63:0] rd_data;
    logic [N-1:0] ipi_irq, tmr_irq, ipi_dup, ipi_miss;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] m_ipi = '0, m_tmr = '0, m_dup = '0, m_miss = '0;

    always #(PERIOD/2) clk = ~clk;

    ipi_timer_intc #(.NCPU(N)) i_ipi_timer_intc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .rd_cpu_id(rd_cpu_id), .rd_data(rd_data), .ipi_irq(ipi_irq),
        .tmr_irq(tmr_irq), .ipi_dup(ipi_dup), .ipi_miss(ipi_miss));

    // Reference model: walks the CPUs one at a time in the order clear, request, tick.
    always @(posedge clk) begin
        logic [N-1:0] ni, nt, nd, nm;
        if (rst) begin
            ni = '0; nt = '0; nd = '0; nm = '0;
        end else begin
            ni = m_ipi; nt = m_tmr; nd = '0; nm = '0;
            for (int c = 0; c < N; c++) begin
                if (wr_en && wr_data[8 + c]) begin
                    if (ni[c]) ni[c] = 1'b0;
                    else       nm[c] = 1'b1;
                end
                if (wr_en && wr_data[12 + c]) begin
                    if (ni[c]) nd[c] = 1'b1;
                    else       ni[c] = 1'b1;
                end
                if (wr_en && wr_data[4 + c]) nt[c] = 1'b0;
                if (tick) nt[c] = 1'b1;
            end
        end
        m_ipi  <= ni;
        m_tmr  <= nt;
        m_dup  <= nd;
        m_miss <= nm;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_rd();
        logic [63:0] r;
        r = '0;
        for (int c = 0; c < N; c++) begin
            r[8 + c] = m_ipi[c];
            r[4 + c] = m_tmr[c];
        end
        r[1:0] = rd_cpu_id;
        return r;
    endfunction

    task automatic compare_all();
        chk("R1/R3/R8 ipi_irq", 64'(ipi_irq), 64'(m_ipi));
        chk("R4/R5 tmr_irq", 64'(tmr_irq), 64'(m_tmr));
        chk("R2 ipi_dup", 64'(ipi_dup), 64'(m_dup));
        chk("R3 ipi_miss", 64'(ipi_miss), 64'(m_miss));
        chk("R6/R7 rd_data", rd_data, exp_rd());
    endtask

    task automatic step(input logic w, input logic [63:0] d, input logic t, input logic [1:0] id);
        wr_en = w; wr_data = d; tick = t; rd_cpu_id = id;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 reset ipi", 64'(ipi_irq), 64'd0);
        chk("R10 reset tmr", 64'(tmr_irq), 64'd0);
        rst = 0;
        step(1, 64'h1000, 0, 2'd1);          // R1 request CPU0
        chk("R1 cpu0 posted", 64'(ipi_irq), 64'h1);
        step(1, 64'h9000, 0, 2'd2);          // R2 dup CPU0, R7 bit15 ignored
        chk("R2 dup cpu0", 64'(ipi_dup), 64'h1);
        chk("R7 cpu3 absent", rd_data & 64'h888, 64'd0);
        step(0, 64'h0, 0, 2'd0);
        chk("R2 dup one cycle", 64'(ipi_dup), 64'd0);
        step(1, 64'h0200, 0, 2'd3);          // R3 clear CPU1 not pending
        chk("R3 miss cpu1", 64'(ipi_miss), 64'h2);
        step(1, 64'h0100, 0, 2'd0);          // R3 clear CPU0
        chk("R3 cpu0 cleared", 64'(ipi_irq), 64'd0);
        step(1, 64'h1000, 0, 2'd0);          // CPU0 pending again
        step(1, 64'h1100, 0, 2'd0);          // R8 clear+request CPU0
        chk("R8 clear then request", 64'(ipi_irq), 64'h1);
        chk("R8 no dup", 64'(ipi_dup), 64'd0);
        step(0, 64'h0, 1, 2'd0);             // R5 tick
        chk("R5 tick all", 64'(tmr_irq), 64'h7);
        step(1, 64'h0040, 0, 2'd0);          // R4 clear timer CPU2
        chk("R4 tmr cpu2 cleared", 64'(tmr_irq), 64'h3);
        chk("R4 ipi untouched", 64'(ipi_irq), 64'h1);
        step(1, 64'h0070, 1, 2'd0);          // R5 tick beats clear
        chk("R5 tick wins", 64'(tmr_irq), 64'h7);
        step(1, 64'hFFFF_FFFF_FFFF_000F, 0, 2'd1); // R9 junk bits only
        chk("R9 junk ignored", 64'(ipi_irq), 64'h1);
        step(0, 64'h0000_0000_0000_7770, 0, 2'd1); // R9 no strobe
        chk("R9 no strobe ipi", 64'(ipi_irq), 64'h1);
        chk("R9 no strobe tmr", 64'(tmr_irq), 64'h7);
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            step(($urandom % 4) != 0, d, ($urandom % 8) == 0, 2'($urandom));
        end
        rst = 1;
        step(0, 64'h0, 0, 2'd0);
        chk("R10 reset again", 64'(ipi_irq) | 64'(tmr_irq), 64'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule